// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets a requester inside the chip read and write an external asynchronous static RAM of 65,536 four-bit words. The memory has two active-low controls, a chip select and a write strobe, and no output-enable pin. The memory drives the shared data pins whenever it is selected with the write strobe high, so the controller has to time its own drivers around the write strobe. The pin bus is modelled as three signals: a data-out vector, a data-in vector and a driver-enable.

The requester presents a request with a valid/ready handshake. The request carries a write flag, a 16-bit word address and 4 bits of write data. A read returns 4 bits of data with a one-cycle valid pulse. Each nanosecond limit of the memory (access time, write pulse width, data setup, driver turn-off) is a parameter. A clock-period parameter turns each limit into a whole number of cycles, rounded up and never below one. Between requests the chip select stays high, so the memory sits in standby when there is no traffic.

Top module: `asram_ctrl`

## Requirements
- R1: After a synchronous reset: `mem_ce_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken only at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until the access ends. Whenever `req_ready` is 1, `mem_ce_n` is 1, and it stays 1 for at least one cycle between two accesses.
- R3: A read (`req_write`=0) holds `mem_ce_n`=0 and `mem_we_n`=1 for RD = ceil(T_RC_NS/CLK_PERIOD_NS) cycles, which is 3 at the default values. `mem_addr` holds the requested address and does not change while `mem_ce_n` is 0.
- R4: The read data is sampled from `mem_dq_in` at the clock edge that ends the read. That same edge sets `rsp_valid` to 1 for exactly one cycle, with `rsp_data` equal to the word last written to that address. `rsp_valid` follows the accepting edge by RD cycles.
- R5: A write (`req_write`=1) pulls `mem_ce_n` and `mem_we_n` low together for WR cycles, which is 4 at the default values, and both rise at the same edge. WR is the largest of: ceil(T_WC_NS/P), ceil(T_PWE_NS/P), ceil(T_AW_NS/P), and TURN+SU.
- R6: `mem_dq_oe` goes to 1 only after `mem_we_n` has been 0 for TURN = ceil(T_HZWE_NS/P) cycles (2 at the defaults). It is never 1 while `mem_we_n` or `mem_ce_n` is 1.
- R7: `mem_dq_oe` stays 1 for WR-TURN cycles, which is at least SU = ceil(T_SD_NS/P), and it drops at the same edge where `mem_we_n` rises. `mem_dq_out` carries the request's write data throughout the write.
- R8: A write produces no `rsp_valid` pulse.
- R9: A read returns the most recent data written to its address, at any address including 0x0000 and 0xFFFF, and after any number of overwrites.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data present |
| rsp_data | output | 4 | Read data |
| mem_addr | output | 16 | Memory address pins |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | 4 | Data driven towards the memory |
| mem_dq_in | input | 4 | Data seen on the memory pins |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |

## Verification
The bench uses the default 16-bit address, 4-bit data and the memory's 15/9/10/8/7 ns limits, with a 5 ns clock. At that period the 7 ns turn-off and the 8 ns setup both round up to two cycles, so the write runs 4 cycles, longer than its 15 ns floor. That makes the turnaround and setup sum, not the cycle-time limit, the term that sets the write length. A behavioural memory in the bench returns inverted data when it is sampled before 14 ns of access time. It also timestamps every pin edge to catch short strobes, late data and both sides driving at once. These checks, with the 16-bit address, put the end addresses 0x0000 and 0xFFFF within reach.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding and cycle-rounding helpers for the
// asynchronous SRAM controller. Assumes all nanosecond limits are integers.
package asram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WTURN  = 2'd2,
        ST_WDRIVE = 2'd3
    } asram_state_e;

    // Round a time limit up to whole clock cycles, at least one.
    function automatic int ns_to_cyc(input int lim_ns, input int per_ns);
        int c;
        c = (lim_ns + per_ns - 1) / per_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
// Module: asram_seq
// Access sequencer. It owns the memory control pins (chip select, write
// strobe, driver enable) as flops and counts each phase in cycles.
// Assumes: the phase lengths come in already rounded and are all >= 1.
module asram_seq
    import asram_pkg::*;
#(
    parameter int RD_CYC   = 3,
    parameter int TURN_CYC = 2,
    parameter int DRV_CYC  = 2,
    parameter int CNT_W    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic accept,
    output logic capture,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic mem_dq_oe
);

    asram_state_e     state;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;

    assign cnt_zero  = (cnt == '0);
    assign req_ready = (state == ST_IDLE);
    assign accept    = (state == ST_IDLE) && req_valid;
    assign capture   = (state == ST_READ) && cnt_zero;

    // Phase sequencing and registered control pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        mem_ce_n <= 1'b0;
                        if (req_write) begin
                            mem_we_n <= 1'b0;
                            cnt      <= CNT_W'(TURN_CYC - 1);
                            state    <= ST_WTURN;
                        end else begin
                            cnt      <= CNT_W'(RD_CYC - 1);
                            state    <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (cnt_zero) begin
                        mem_ce_n <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_WTURN: begin
                    if (cnt_zero) begin
                        mem_dq_oe <= 1'b1;
                        cnt       <= CNT_W'(DRV_CYC - 1);
                        state     <= ST_WDRIVE;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_WDRIVE: begin
                    if (cnt_zero) begin
                        mem_we_n  <= 1'b1;
                        mem_ce_n  <= 1'b1;
                        mem_dq_oe <= 1'b0;
                        state     <= ST_IDLE;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: drivers on only inside a selected write strobe.
    p_oe_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_ce_n));

    // R6: drivers never switch on in the same cycle the strobe falls.
    p_oe_after_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(!mem_we_n));

    // R7: drivers are released at the edge where the strobe rises.
    p_release_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_dq_oe && $past(mem_dq_oe)));

    // R5: write strobe only ever low with the chip selected.
    p_we_inside_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    // R2: idle means standby.
    p_idle_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n);

endmodule

// File: rtl/asram_data.sv
`timescale 1ns/1ps
// Module: asram_data
// Address/data path: latches the request on accept, samples the memory
// pins on the capture strobe and issues the one-cycle response pulse.
// Assumes: accept and capture never coincide (sequencer guarantees it).
module asram_data #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_valid
);

    // Hold address and write data for the whole access; sample read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            rsp_data   <= '0;
            rsp_valid  <= 1'b0;
        end else begin
            rsp_valid <= capture;
            if (accept) begin
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
            end
            if (capture) begin
                rsp_data <= mem_dq_in;
            end
        end
    end

    // R4: the response is a single-cycle pulse.
    p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
// Module: asram_ctrl (top)
// Synchronous controller for an external asynchronous SRAM that has only
// chip-select and write-strobe controls. It turns the nanosecond limits
// into cycle counts and joins the sequencer with the data path.
// Assumes: integer nanosecond clock period; the bus is split into
// out/in/enable and a pad ring forms the tri-state pins.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 4,
    parameter int CLK_PERIOD_NS = 5,
    parameter int T_RC_NS       = 15,
    parameter int T_WC_NS       = 15,
    parameter int T_PWE_NS      = 9,
    parameter int T_AW_NS       = 10,
    parameter int T_SD_NS       = 8,
    parameter int T_HZWE_NS     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int RD_CYC   = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int TURN_CYC = ns_to_cyc(T_HZWE_NS, CLK_PERIOD_NS);
    localparam int SU_CYC   = ns_to_cyc(T_SD_NS, CLK_PERIOD_NS);
    localparam int WR_CYC   = imax(imax(ns_to_cyc(T_WC_NS, CLK_PERIOD_NS),
                                        ns_to_cyc(T_PWE_NS, CLK_PERIOD_NS)),
                                   imax(ns_to_cyc(T_AW_NS, CLK_PERIOD_NS),
                                        TURN_CYC + SU_CYC));
    localparam int DRV_CYC  = WR_CYC - TURN_CYC;
    localparam int MAX_CYC  = imax(RD_CYC, imax(TURN_CYC, DRV_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic accept;
    logic capture;

    asram_seq #(
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .DRV_CYC  (DRV_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_oe (mem_dq_oe)
    );

    asram_data #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rsp_data   (rsp_data),
        .rsp_valid  (rsp_valid)
    );

    // R3: the address pins hold still while the chip stays selected.
    p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R4: a response only follows a selected read cycle.
    p_rsp_from_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_ce_n && mem_we_n));

    // R8: a response never follows a write-strobe cycle.
    p_no_rsp_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mem_we_n));

endmodule

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench with a timing-checking behavioural memory model.
module asram_ctrl_test;

    localparam int P = 5;
    function automatic int up(input int n);
        int c;
        c = (n + P - 1) / P;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int RD   = up(15);
    localparam int TURN = up(7);
    localparam int SU   = up(8);
    localparam int WR0  = (up(15) > up(9)) ? up(15) : up(9);
    localparam int WR1  = (up(10) > TURN + SU) ? up(10) : TURN + SU;
    localparam int WR   = (WR0 > WR1) ? WR0 : WR1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_data;
    logic [15:0] mem_addr;
    logic        mem_ce_n;
    logic        mem_we_n;
    logic [3:0]  mem_dq_out;
    logic [3:0]  mem_dq_in = '0;
    logic        mem_dq_oe;

    int checks = 0;
    int fails  = 0;
    int model_errs = 0;

    logic [3:0] marr    [int unsigned];
    logic [3:0] ref_arr [int unsigned];

    always #2.5 clk = ~clk;

    asram_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // ---------------- behavioural memory with timing checks ----------------
    realtime t_ce_fall = 0, t_we_fall = 0, t_wstart = 0, t_oe_rise = 0;
    realtime t_oe_fall = 0, t_dchg = 0, t_addr = 0, t_acc = 0;
    bit wr_on = 0;
    logic p_ce = 1'b0, p_we = 1'b0, p_oe = 1'b0;
    logic [3:0]  p_dout = '0;
    logic [15:0] p_addr = '0;

    task automatic violation(input string what);
        model_errs++;
        $display("%0t timing violation: %s", $realtime, what);
    endtask

    always @(mem_ce_n or mem_we_n or mem_dq_oe or mem_dq_out or mem_addr or rst_n) begin
        realtime now, dstart;
        now = $realtime;
        if (p_ce && !mem_ce_n) t_ce_fall = now;
        if (p_we && !mem_we_n) t_we_fall = now;
        if (!p_oe && mem_dq_oe) t_oe_rise = now;
        if (p_oe && !mem_dq_oe) t_oe_fall = now;
        if (mem_dq_out != p_dout) t_dchg = now;
        if (mem_addr != p_addr) begin t_addr = now; t_acc = now; end
        if (p_ce && !mem_ce_n) t_acc = now;
        if (rst_n) begin
            if (!wr_on && !mem_ce_n && !mem_we_n) begin
                wr_on = 1; t_wstart = now;
            end else if (wr_on && (mem_ce_n || mem_we_n)) begin
                wr_on = 0;
                dstart = (t_oe_rise > t_dchg) ? t_oe_rise : t_dchg;
                if (now - t_wstart < 8.999) violation("write pulse short");
                if (now - t_ce_fall < 9.999) violation("select to write end short");
                if (now - t_addr < 9.999) violation("address setup short");
                if (t_oe_rise < t_wstart || !(mem_dq_oe || t_oe_fall == now))
                    violation("data not driven at write end");
                if (now - dstart < 7.999) violation("data setup short");
                marr[mem_addr] = mem_dq_out;
            end
            if (!p_ce && mem_ce_n && p_we && mem_we_n && now - t_ce_fall < 14.999)
                violation("read cycle short");
            if (mem_dq_oe && !mem_ce_n && (mem_we_n || now - t_we_fall < 6.999))
                violation("bus contention");
        end
        p_ce = mem_ce_n; p_we = mem_we_n; p_oe = mem_dq_oe;
        p_dout = mem_dq_out; p_addr = mem_addr;
    end

    // Read path: correct data only after 14 ns of access (1 ns grain), else inverted.
    initial begin
        #0.5;
        forever begin
            logic [3:0] w;
            w = marr.exists(mem_addr) ? marr[mem_addr] : 4'h0;
            if (!mem_ce_n && mem_we_n && ($realtime - t_acc) >= 14.0) mem_dq_in = w;
            else mem_dq_in = ~w;
            #1;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $realtime);
        end
    endtask

    // Called at a negedge; returns at the negedge where the write is done.
    task automatic do_write(input logic [15:0] a, input logic [3:0] d);
        check(req_ready == 1'b1, "R2 ready before write", int'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        for (int i = 0; i <= WR; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (i < WR) begin
                check(mem_we_n == 1'b0 && mem_ce_n == 1'b0, "R5 strobe low",
                      int'({mem_ce_n, mem_we_n}), 0);
                check(mem_dq_oe == (i >= TURN), "R6 driver timing",
                      int'(mem_dq_oe), int'(i >= TURN));
                check(req_ready == 1'b0, "R2 busy during write", int'(req_ready), 0);
                check(mem_addr == a, "R3 address held", int'(mem_addr), int'(a));
                if (mem_dq_oe)
                    check(mem_dq_out == d, "R7 write data", int'(mem_dq_out), int'(d));
            end else begin
                check(mem_we_n && mem_ce_n && !mem_dq_oe, "R7 release with strobe",
                      int'({mem_ce_n, mem_we_n, mem_dq_oe}), 6);
                check(req_ready == 1'b1, "R2 ready after write", int'(req_ready), 1);
            end
            check(rsp_valid == 1'b0, "R8 no response on write", int'(rsp_valid), 0);
        end
        ref_arr[a] = d;
    endtask

    task automatic do_read(input logic [15:0] a);
        logic [3:0] exp;
        exp = ref_arr.exists(a) ? ref_arr[a] : 4'h0;
        check(req_ready == 1'b1, "R2 ready before read", int'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        for (int i = 0; i <= RD; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (i < RD) begin
                check(!mem_ce_n && mem_we_n && !mem_dq_oe, "R3 read pins",
                      int'({mem_ce_n, mem_we_n, mem_dq_oe}), 2);
                check(mem_addr == a, "R3 address held", int'(mem_addr), int'(a));
                check(rsp_valid == 1'b0, "R4 no early response", int'(rsp_valid), 0);
            end else begin
                check(rsp_valid == 1'b1, "R4 response latency", int'(rsp_valid), 1);
                check(rsp_data == exp, "R9 read data", int'(rsp_data), int'(exp));
                check(mem_ce_n == 1'b1, "R2 standby after read", int'(mem_ce_n), 1);
            end
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_we_n, "R1 controls idle", int'({mem_ce_n, mem_we_n}), 3);
        check(!mem_dq_oe, "R1 drivers off", int'(mem_dq_oe), 0);
        check(req_ready, "R1 ready", int'(req_ready), 1);
        check(!rsp_valid, "R1 no response", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_ends();
        do_write(16'h0000, 4'hF);
        do_write(16'hFFFF, 4'h0);
        do_read(16'h0000);
        do_read(16'hFFFF);
    endtask

    task automatic t_walk();
        for (int k = 0; k < 16; k++) do_write(16'(1 << k), 4'(k ^ 5));
        for (int k = 15; k >= 0; k--) do_read(16'(1 << k));
    endtask

    task automatic t_overwrite();
        do_write(16'h1234, 4'hA);
        do_write(16'h1234, 4'h5);
        do_read(16'h1234);
        do_write(16'h1234, 4'h3);
        do_read(16'h1234);
    endtask

    task automatic t_pulse_and_idle();
        do_read(16'h0000);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R4 single-cycle pulse", int'(rsp_valid), 0);
        for (int i = 0; i < 4; i++) begin
            check(mem_ce_n && req_ready, "R2 idle standby",
                  int'({mem_ce_n, req_ready}), 3);
            @(negedge clk);
        end
    endtask

    task automatic t_timing();
        check(model_errs == 0, "R6 R7 memory timing rules", model_errs, 0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_ends();
        t_walk();
        t_overwrite();
        t_pulse_and_idle();
        t_timing();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule